// File: doc/BRIEF.md
# Six-Control Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a small accumulator-style processor datapath. It takes two operands and six independent control bits. Every operation comes from one fixed chain of steps. Each operand may be cleared and then bit-inverted. The two conditioned operands are then either added or ANDed. The result may be inverted once more before it leaves the block.

Picking the six bits selects constants such as 0, 1 and -1, the operands themselves, their complements and negations, and sums, differences and bitwise ANDs. Alongside the result the block reports two flags: one says the result is zero, the other says its top bit is set. A decoder upstream drives the six bits straight from an instruction field. The result and flags are registered downstream, because the block holds no state of its own.

Top module: `alu6_core`

## Requirements
- R1: When `clr_a`=1, operand `a` is replaced by all zeros before the optional inversion is applied to it.
- R2: When `inv_a`=1, the operand `a` (after any clearing) is bitwise inverted.
- R3: `clr_b` and `inv_b` act on operand `b` exactly as `clr_a` and `inv_a` act on `a`.
- R4: When `sel_add`=1, the core result is the sum of the two conditioned operands modulo 2^WIDTH. The carry out of the top bit is dropped and no overflow indication is produced.
- R5: When `sel_add`=0, the core result is the bitwise AND of the two conditioned operands.
- R6: When `inv_res`=1, the core result is bitwise inverted before it drives `res`; otherwise it drives `res` unchanged.
- R7: `is_zero` is 1 exactly when every bit of `res` is 0. It is formed by OR-reducing the lower and upper halves of `res` and inverting the combined result.
- R8: `is_neg` equals the most significant bit of `res`.
- R9: With the control bits {clr_a,inv_a,clr_b,inv_b,sel_add,inv_res} = 111111, `res` is the constant 1 for any operands.
- R10: With the control bits {clr_a,inv_a,clr_b,inv_b,sel_add,inv_res} = 111010, `res` is all ones (-1) for any operands.
- R11: With the control bits {clr_a,inv_a,clr_b,inv_b,sel_add,inv_res} = 001100, `res` equals `a` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| clr_a | input | 1 | Clear the first operand to zero |
| inv_a | input | 1 | Bitwise invert the (possibly cleared) first operand |
| clr_b | input | 1 | Clear the second operand to zero |
| inv_b | input | 1 | Bitwise invert the (possibly cleared) second operand |
| sel_add | input | 1 | 1 selects addition, 0 selects bitwise AND |
| inv_res | input | 1 | Bitwise invert the result before output |
| res | output | WIDTH | Result |
| is_zero | output | 1 | Result equals zero |
| is_neg | output | 1 | Result most significant bit |

## Verification
Clearing and inverting the same operand can happen in the same evaluation. When both bits are set, the operand becomes all ones, and this only works if the steps run in the stated order. The random control patterns hit this case often, and the directed constant codes depend on it. The reference model in the bench applies the steps in the order the requirements give. A second overlap is the adder wrapping past its top bit at the same moment the zero flag must rise. This is provoked with directed operands whose sum is exactly 2^WIDTH, and it is judged by comparing both the result and the flag.

// File: rtl/alu6_pkg.sv
package alu6_pkg;
  typedef struct packed {
    logic clr;
    logic inv;
  } opnd_ctrl_t;
endpackage

// File: rtl/alu6_opnd.sv
module alu6_opnd #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]    din,
  input  alu6_pkg::opnd_ctrl_t ctl,
  output logic [WIDTH-1:0]    dout
);
  logic [WIDTH-1:0] cleared;

  always_comb begin
    cleared = ctl.clr ? '0 : din;
    dout    = ctl.inv ? ~cleared : cleared;
  end

  // R1/R2: the clear step comes before the inversion step
  always_comb begin
    if (ctl.clr) begin
      assert_clear_first_R1: assert (dout == (ctl.inv ? {WIDTH{1'b1}} : {WIDTH{1'b0}}));
    end
    if (!ctl.clr && ctl.inv) begin
      assert_invert_R2: assert ((dout ^ din) == {WIDTH{1'b1}});
    end
  end
endmodule

// File: rtl/alu6_func.sv
module alu6_func #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             sel_add,
  output logic [WIDTH-1:0] core
);
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] conj;

  always_comb begin
    sum  = opa + opb;
    conj = opa & opb;
    core = sel_add ? sum : conj;
  end

  always_comb begin
    if (sel_add) begin
      assert_add_wraps_R4: assert ((core - opb) == opa);
    end else begin
      assert_and_subset_R5: assert (((core & ~opa) | (core & ~opb)) == '0);
    end
  end
endmodule

// File: rtl/alu6_post.sv
module alu6_post #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] core,
  input  logic             inv_res,
  output logic [WIDTH-1:0] res,
  output logic             is_zero,
  output logic             is_neg
);
  localparam int HALF = WIDTH / 2;

  logic lo_any;
  logic hi_any;

  always_comb begin
    res     = inv_res ? ~core : core;
    lo_any  = |res[HALF-1:0];
    hi_any  = |res[WIDTH-1:HALF];
    is_zero = ~(lo_any | hi_any);
    is_neg  = res[WIDTH-1];
  end

  always_comb begin
    if (inv_res) begin
      assert_post_invert_R6: assert ((res ^ core) == {WIDTH{1'b1}});
    end else begin
      assert_post_pass_R6: assert (res == core);
    end
  end
endmodule

// File: rtl/alu6_core.sv
module alu6_core #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             clr_a,
  input  logic             inv_a,
  input  logic             clr_b,
  input  logic             inv_b,
  input  logic             sel_add,
  input  logic             inv_res,
  output logic [WIDTH-1:0] res,
  output logic             is_zero,
  output logic             is_neg
);
  alu6_pkg::opnd_ctrl_t ctl_a;
  alu6_pkg::opnd_ctrl_t ctl_b;
  logic [WIDTH-1:0]     opa;
  logic [WIDTH-1:0]     opb;
  logic [WIDTH-1:0]     core;

  always_comb begin
    ctl_a = '{clr: clr_a, inv: inv_a};
    ctl_b = '{clr: clr_b, inv: inv_b};
  end

  alu6_opnd #(.WIDTH(WIDTH)) u_opa (.din(a), .ctl(ctl_a), .dout(opa));
  alu6_opnd #(.WIDTH(WIDTH)) u_opb (.din(b), .ctl(ctl_b), .dout(opb));

  alu6_func #(.WIDTH(WIDTH)) u_func (
    .opa(opa), .opb(opb), .sel_add(sel_add), .core(core)
  );

  alu6_post #(.WIDTH(WIDTH)) u_post (
    .core(core), .inv_res(inv_res), .res(res), .is_zero(is_zero), .is_neg(is_neg)
  );

  always_comb begin
    assert_zero_flag_R7: assert (is_zero == (res == '0));
    assert_neg_flag_R8: assert (is_neg == res[WIDTH-1]);
    if (clr_b && inv_b && !clr_a && !inv_a && !sel_add && !inv_res) begin
      assert_pass_a_R11: assert (res == a);
    end
    if (clr_a && inv_a && clr_b && inv_b && sel_add && inv_res) begin
      assert_const_one_R9: assert (res == WIDTH'(1));
    end
    if (clr_a && inv_a && clr_b && !inv_b && sel_add && !inv_res) begin
      assert_minus_one_R10: assert (res == {WIDTH{1'b1}});
    end
    if (clr_b) begin
      assert_clear_b_R3: assert (opb == (inv_b ? {WIDTH{1'b1}} : {WIDTH{1'b0}}));
    end
  end
endmodule

// File: tb/sim_alu6_core.sv
module sim_alu6_core;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic [W-1:0] a, b, res;
  logic         clr_a, inv_a, clr_b, inv_b, sel_add, inv_res;
  logic         is_zero, is_neg;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  alu6_core #(.WIDTH(W)) u0 (
    .a(a), .b(b), .clr_a(clr_a), .inv_a(inv_a), .clr_b(clr_b), .inv_b(inv_b),
    .sel_add(sel_add), .inv_res(inv_res), .res(res), .is_zero(is_zero), .is_neg(is_neg)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic [5:0] c);
    logic [W-1:0] px, py, r;
    px = c[5] ? '0 : x;
    px = c[4] ? ~px : px;
    py = c[3] ? '0 : y;
    py = c[2] ? ~py : py;
    r  = c[1] ? px + py : px & py;
    return c[0] ? ~r : r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic [5:0] c,
                       input string tag);
    logic [W-1:0] e;
    @(posedge clk);
    a = x; b = y;
    {clr_a, inv_a, clr_b, inv_b, sel_add, inv_res} = c;
    @(negedge clk);
    e = model(x, y, c);
    check(tag, res, e);
    check("R7", W'(is_zero), W'(e == '0));
    check("R8", W'(is_neg), W'(e[W-1]));
  endtask

  initial begin
    int unsigned seed = 32'd2024;
    void'($urandom(seed));
    a = '0; b = '0;
    {clr_a, inv_a, clr_b, inv_b, sel_add, inv_res} = '0;
    @(negedge clk);
    check("R5 idle", res, '0);
    check("R7 idle", W'(is_zero), W'(1));
    apply(16'h1234, 16'hBEEF, 6'b111111, "R9");
    apply(16'hFFFF, 16'h0000, 6'b111111, "R9");
    apply(16'h5A5A, 16'h0F0F, 6'b111010, "R10");
    apply(16'hA5C3, 16'h7777, 6'b001100, "R11");
    apply(16'h8000, 16'h0000, 6'b001100, "R11");
    apply(16'hABCD, 16'h0001, 6'b100010, "R1");
    apply(16'hABCD, 16'h0000, 6'b010010, "R2");
    apply(16'h0000, 16'hF0F0, 6'b000110, "R3");
    apply(16'h7FFF, 16'h0001, 6'b000010, "R4");
    apply(16'hFFFF, 16'h0001, 6'b000010, "R4");
    apply(16'h0009, 16'h0004, 6'b010011, "R4");
    apply(16'hF0F0, 16'h3C3C, 6'b000000, "R5");
    apply(16'hF0F0, 16'h3C3C, 6'b000001, "R6");
    apply(16'h00FF, 16'hFF00, 6'b000011, "R6");
    for (int i = 0; i < 400; i++) begin
      apply(W'($urandom), W'($urandom), 6'($urandom), "R4/R5/R6 random");
    end
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 100000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule